// File: doc/BRIEF.md
# Coprocessor Mailbox and Control Register Block

This block is the register window through which a host processor supervises a small embedded controller. The host reaches it over a plain 32-bit register bus (valid, write, byte address, write data, combinational read data). Through it the host lets the controller run or holds it in reset, chooses how the tightly coupled memory is divided between program and data, arms a watchdog, and posts messages by ringing a doorbell.

The controller side sees the run level, the doorbell level and the memory split. It returns an acknowledge strobe that drops the doorbell, a strobe that raises a message cause toward the host, a watchdog kick, and its program counter, which the host can read for debug. Message and watchdog causes share one interrupt line. A cause stays latched until the host clears it by writing zero. Events that arrive while a cause is latched wait in a pending stage and are shown after the clear.

Top module: `copro_mailbox_regs`

## Requirements
- R1: The register offsets are 0x00 run control, 0x08 memory split, 0x1C cause, 0x24 doorbell, 0x60 program counter (read-only) and 0x84 watchdog. After reset every register reads 0 and `host_irq` is 0.
- R2: Bit 0 of offset 0x00 drives `ctl_run` (1 = run, 0 = held in reset), and a read of 0x00 returns that bit in bit 0.
- R3: Writing a word with bit 0 set to 0x24 raises the doorbell, so 0x24 reads 1 and `ctl_doorbell` is 1. A host write of 0 does not lower it. Only a `ctl_db_ack` pulse lowers it, and a host set in the same cycle as an acknowledge wins.
- R4: A `ctl_ipc_raise` pulse sets bit 8 of the cause register (value 0x100). `host_irq` is 1 whenever the cause register is nonzero.
- R5: A latched cause holds until the host writes 0 to 0x1C, and nonzero writes there are ignored. Events that arrive while a cause is latched, or in the clear cycle, are presented one cycle after the clear.
- R6: Bit 31 of offset 0x84 enables the watchdog. All 32 bits read back exactly as written, so a read-modify-write of bit 31 keeps the rest.
- R7: While enabled and running, the watchdog sets cause bit 0 (value 0x1) WDT_LIMIT cycles after enable or the last kick. A `ctl_wdt_kick` pulse restarts the count.
- R8: After an expiry the watchdog stops and raises no further cause until it is kicked or disabled.
- R9: While bit 0 of 0x00 is 0, the doorbell is cleared and host doorbell writes are ignored, the watchdog count is held at zero, and 0x60 reads 0.
- R10: Reads of unmapped offsets return 0, and writes to them change no register.
- R11: The low TCM_W bits of 0x08 hold the memory split code and drive `tcm_split`. Code 2 selects the 96 KiB program / 32 KiB data split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_valid | input | 1 | Host bus access valid |
| hst_write | input | 1 | 1 = write, 0 = read |
| hst_addr | input | ADDR_W | Byte offset |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Read data (combinational) |
| host_irq | output | 1 | Interrupt to the host, high while any cause is set |
| ctl_run | output | 1 | Controller run enable |
| ctl_doorbell | output | 1 | Doorbell level toward the controller |
| ctl_db_ack | input | 1 | Controller acknowledges the doorbell |
| ctl_ipc_raise | input | 1 | Controller raises a message cause |
| ctl_wdt_kick | input | 1 | Controller restarts the watchdog |
| ctl_pc | input | PC_W | Controller program counter |
| tcm_split | output | TCM_W | Memory split code |

## Verification
A table of register reads and writes first separates correct offset decoding from aliasing. It reads each mapped offset, an unmapped one, and the program counter both held and running. Cause handling is driven with a single event, an event that arrives while a cause is latched, and a nonzero write to the cause register, which tells holding apart from losing events and from clearing too early. The watchdog runs kicked well inside its window, left to expire at the exact cycle, left idle long after expiry, and enabled while the controller is held. These patterns tell timeout accuracy apart from repeated firing and from counting in reset.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [7:0] OFF_RUN   = 8'h00;
  localparam logic [7:0] OFF_TCM   = 8'h08;
  localparam logic [7:0] OFF_CAUSE = 8'h1C;
  localparam logic [7:0] OFF_DB    = 8'h24;
  localparam logic [7:0] OFF_PC    = 8'h60;
  localparam logic [7:0] OFF_WDT   = 8'h84;

  localparam int CAUSE_IPC_BIT = 8;
  localparam int CAUSE_WDT_BIT = 0;
  localparam int WDT_EN_BIT    = 31;

  typedef struct packed {
    logic ipc;
    logic wdt;
  } evt_t;

  function automatic logic [31:0] cause_word(evt_t e);
    logic [31:0] w;
    w = '0;
    w[CAUSE_IPC_BIT] = e.ipc;
    w[CAUSE_WDT_BIT] = e.wdt;
    return w;
  endfunction

  function automatic logic is_mapped(logic [7:0] a);
    return (a == OFF_RUN) || (a == OFF_TCM) || (a == OFF_CAUSE) ||
           (a == OFF_DB) || (a == OFF_PC) || (a == OFF_WDT);
  endfunction
endpackage

// File: rtl/mbx_ctrl_regs.sv
module mbx_ctrl_regs #(
  parameter int PC_W  = 32,
  parameter int TCM_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_run,
  input  logic             wr_tcm,
  input  logic             wr_wdt,
  input  logic             wr_db,
  input  logic [31:0]      wdata,
  input  logic             db_ack,
  input  logic [PC_W-1:0]  pc_in,
  output logic             run_q,
  output logic [TCM_W-1:0] tcm_q,
  output logic [31:0]      wdt_q,
  output logic             db_q,
  output logic [PC_W-1:0]  pc_q
);
  logic db_set;
  assign db_set = wr_db && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      tcm_q <= '0;
      wdt_q <= '0;
    end else begin
      if (wr_run) run_q <= wdata[0];
      if (wr_tcm) tcm_q <= wdata[TCM_W-1:0];
      if (wr_wdt) wdt_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      db_q <= 1'b0;
    else if (!run_q) db_q <= 1'b0;
    else if (db_set) db_q <= 1'b1;
    else if (db_ack) db_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (run_q) pc_q <= pc_in;
    else            pc_q <= '0;
  end

  assert_db_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (db_q && !db_ack && run_q) |=> db_q);
  assert_db_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (db_set && run_q) |=> db_q);
  assert_db_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !db_q);
  assert_pc_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (pc_q == '0));
endmodule

// File: rtl/mbx_cause.sv
module mbx_cause
  import mbx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_clr,
  input  logic        ipc_evt,
  input  logic        wdt_evt,
  output logic [31:0] cause_o,
  output logic        irq_o
);
  evt_t cause_q, pend_q, incoming, merged;

  always_comb begin
    incoming.ipc = ipc_evt;
    incoming.wdt = wdt_evt;
    merged = evt_t'(pend_q | incoming);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      pend_q  <= '0;
    end else if (host_clr) begin
      cause_q <= '0;
      pend_q  <= merged;
    end else if (cause_q == '0) begin
      cause_q <= merged;
      pend_q  <= '0;
    end else begin
      pend_q  <= merged;
    end
  end

  assign cause_o = cause_word(cause_q);
  assign irq_o   = |cause_q;

  assert_cause_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q != '0 && !host_clr) |=> (cause_q == $past(cause_q)));
  assert_cause_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    host_clr |=> !irq_o);
  assert_no_loss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q != '0 && incoming != '0) |=> (pend_q != '0));
  assert_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q == '0 && pend_q == '0 && incoming == '0) |=> !irq_o);
endmodule

// File: rtl/mbx_wdog.sv
module mbx_wdog #(
  parameter int WDT_LIMIT = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic run,
  input  logic kick,
  output logic fire
);
  localparam int CNT_W = $clog2(WDT_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WDT_LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             exp_q;
  logic             active;

  assign active = en && run && !exp_q;
  assign fire   = active && !kick && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (!en || !run) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (kick) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (fire) begin
      exp_q <= 1'b1;
    end else if (active) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_fire_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0 && !fire));
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_kick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !fire);
endmodule

// File: rtl/copro_mailbox_regs.sv
module copro_mailbox_regs
  import mbx_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PC_W      = 32,
  parameter int TCM_W     = 2,
  parameter int WDT_LIMIT = 65536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_valid,
  input  logic              hst_write,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [31:0]       hst_wdata,
  output logic [31:0]       hst_rdata,
  output logic              host_irq,
  output logic              ctl_run,
  output logic              ctl_doorbell,
  input  logic              ctl_db_ack,
  input  logic              ctl_ipc_raise,
  input  logic              ctl_wdt_kick,
  input  logic [PC_W-1:0]   ctl_pc,
  output logic [TCM_W-1:0]  tcm_split
);
  logic [7:0] off;
  assign off = 8'(hst_addr);

  logic wr, wr_run, wr_tcm, wr_cause, wr_db, wr_wdt, host_clr;
  assign wr       = hst_valid && hst_write;
  assign wr_run   = wr && (off == OFF_RUN);
  assign wr_tcm   = wr && (off == OFF_TCM);
  assign wr_cause = wr && (off == OFF_CAUSE);
  assign wr_db    = wr && (off == OFF_DB);
  assign wr_wdt   = wr && (off == OFF_WDT);
  assign host_clr = wr_cause && (hst_wdata == 32'd0);

  logic             run_q, db_q, wdt_fire;
  logic [TCM_W-1:0] tcm_q;
  logic [31:0]      wdt_q, cause_w;
  logic [PC_W-1:0]  pc_q;

  mbx_ctrl_regs #(.PC_W(PC_W), .TCM_W(TCM_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_run(wr_run), .wr_tcm(wr_tcm), .wr_wdt(wr_wdt), .wr_db(wr_db),
    .wdata(hst_wdata), .db_ack(ctl_db_ack), .pc_in(ctl_pc),
    .run_q(run_q), .tcm_q(tcm_q), .wdt_q(wdt_q), .db_q(db_q), .pc_q(pc_q)
  );

  mbx_wdog #(.WDT_LIMIT(WDT_LIMIT)) u_wdog (
    .clk(clk), .rst_n(rst_n), .en(wdt_q[WDT_EN_BIT]), .run(run_q),
    .kick(ctl_wdt_kick), .fire(wdt_fire)
  );

  mbx_cause u_cause (
    .clk(clk), .rst_n(rst_n), .host_clr(host_clr),
    .ipc_evt(ctl_ipc_raise), .wdt_evt(wdt_fire),
    .cause_o(cause_w), .irq_o(host_irq)
  );

  always_comb begin
    case (off)
      OFF_RUN:   hst_rdata = {31'd0, run_q};
      OFF_TCM:   hst_rdata = 32'(tcm_q);
      OFF_CAUSE: hst_rdata = cause_w;
      OFF_DB:    hst_rdata = {31'd0, db_q};
      OFF_PC:    hst_rdata = 32'(pc_q);
      OFF_WDT:   hst_rdata = wdt_q;
      default:   hst_rdata = 32'd0;
    endcase
  end

  assign ctl_run      = run_q;
  assign ctl_doorbell = db_q;
  assign tcm_split    = tcm_q;

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !is_mapped(off) |-> (hst_rdata == 32'd0));
  assert_irq_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (off == OFF_CAUSE && hst_rdata != 32'd0) |-> host_irq);
  assert_run_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_run |=> (ctl_run == $past(hst_wdata[0])));
endmodule

// File: tb/copro_mailbox_regs_bench.sv
module copro_mailbox_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int L = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_valid = 1'b0, hst_write = 1'b0;
  logic [7:0]  hst_addr = '0;
  logic [31:0] hst_wdata = '0;
  logic [31:0] hst_rdata;
  logic        host_irq, ctl_run, ctl_doorbell;
  logic        ctl_db_ack = 1'b0, ctl_ipc_raise = 1'b0, ctl_wdt_kick = 1'b0;
  logic [31:0] ctl_pc = 32'h0000ABC0;
  logic [1:0]  tcm_split;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  copro_mailbox_regs #(.WDT_LIMIT(L)) u_copro_mailbox_regs (
    .clk(clk), .rst_n(rst_n), .hst_valid(hst_valid), .hst_write(hst_write),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .host_irq(host_irq), .ctl_run(ctl_run), .ctl_doorbell(ctl_doorbell),
    .ctl_db_ack(ctl_db_ack), .ctl_ipc_raise(ctl_ipc_raise),
    .ctl_wdt_kick(ctl_wdt_kick), .ctl_pc(ctl_pc), .tcm_split(tcm_split)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  // R1 reset values and offsets, R2 run, R6 watchdog word, R10 unmapped, R11 split
  localparam vec_t VEC [15] = '{
    '{1'b0, 8'h00, 32'h0, 32'h0},
    '{1'b0, 8'h24, 32'h0, 32'h0},
    '{1'b0, 8'h1C, 32'h0, 32'h0},
    '{1'b1, 8'h08, 32'h2, 32'h0},
    '{1'b0, 8'h08, 32'h0, 32'h2},
    '{1'b1, 8'h84, 32'h12345678, 32'h0},
    '{1'b0, 8'h84, 32'h0, 32'h12345678},
    '{1'b1, 8'h40, 32'hFFFFFFFF, 32'h0},
    '{1'b0, 8'h40, 32'h0, 32'h0},
    '{1'b0, 8'h60, 32'h0, 32'h0},
    '{1'b1, 8'h00, 32'h1, 32'h0},
    '{1'b0, 8'h00, 32'h0, 32'h1},
    '{1'b0, 8'h60, 32'h0, 32'h0000ABC0},
    '{1'b0, 8'h08, 32'h0, 32'h2},
    '{1'b0, 8'h04, 32'h0, 32'h0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    hst_valid = 1'b1; hst_write = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_valid = 1'b0; hst_write = 1'b0;
  endtask

  task automatic rd_now(input logic [7:0] a, output logic [31:0] d);
    hst_valid = 1'b1; hst_write = 1'b0; hst_addr = a;
    #1 d = hst_rdata;
    hst_valid = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) ctl_db_ack = 1'b1;
    else if (which == 1) ctl_ipc_raise = 1'b1;
    else ctl_wdt_kick = 1'b1;
    @(negedge clk);
    ctl_db_ack = 1'b0; ctl_ipc_raise = 1'b0; ctl_wdt_kick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {31'd0, host_irq}, 32'd0);
    check("R2 run in reset", {31'd0, ctl_run}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 15; i++) begin
      if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
      else begin
        @(negedge clk);
        rd_now(VEC[i].addr, d);
        check($sformatf("R1/R2/R6/R10/R11 row %0d", i), d, VEC[i].exp);
      end
    end
    check("R2 ctl_run", {31'd0, ctl_run}, 32'd1);
    check("R11 tcm_split 96/32", {30'd0, tcm_split}, 32'd2);

    // R3 doorbell
    wr(8'h24, 32'h1);
    rd_now(8'h24, d); check("R3 doorbell set", d, 32'h1);
    check("R3 ctl_doorbell", {31'd0, ctl_doorbell}, 32'd1);
    wr(8'h24, 32'h0);
    rd_now(8'h24, d); check("R3 host zero ignored", d, 32'h1);
    pulse(0);
    rd_now(8'h24, d); check("R3 ack clears", d, 32'h0);

    // R4 / R5 cause
    pulse(1);
    rd_now(8'h1C, d); check("R4 ipc cause", d, 32'h100);
    check("R4 irq high", {31'd0, host_irq}, 32'd1);
    pulse(1);
    wr(8'h1C, 32'h100);
    rd_now(8'h1C, d); check("R5 nonzero write ignored", d, 32'h100);
    wr(8'h1C, 32'h0);
    rd_now(8'h1C, d); check("R5 cleared", d, 32'h0);
    check("R5 irq low after clear", {31'd0, host_irq}, 32'd0);
    @(negedge clk);
    rd_now(8'h1C, d); check("R5 pending presented", d, 32'h100);
    wr(8'h1C, 32'h0);
    @(negedge clk);
    rd_now(8'h1C, d); check("R5 nothing pending", d, 32'h0);

    // R6 / R7 / R8 watchdog
    rd_now(8'h84, d);
    wr(8'h84, d | 32'h80000000);
    rd_now(8'h84, d); check("R6 rmw enable", d, 32'h92345678);
    for (int k = 0; k < 4; k++) begin
      repeat (L-4) @(negedge clk);
      pulse(2);
    end
    rd_now(8'h1C, d); check("R7 kicked no cause", d, 32'h0);
    repeat (L-1) @(negedge clk);
    rd_now(8'h1C, d); check("R7 one cycle before expiry", d, 32'h0);
    @(negedge clk);
    rd_now(8'h1C, d); check("R7 expiry cause", d, 32'h1);
    check("R7 irq on expiry", {31'd0, host_irq}, 32'd1);
    repeat (3*L) @(negedge clk);
    wr(8'h1C, 32'h0);
    repeat (2) @(negedge clk);
    rd_now(8'h1C, d); check("R8 no refire", d, 32'h0);
    repeat (2*L) @(negedge clk);
    rd_now(8'h1C, d); check("R8 still stopped", d, 32'h0);
    pulse(2);
    repeat (L-1) @(negedge clk);
    rd_now(8'h1C, d); check("R7 rearmed before", d, 32'h0);
    @(negedge clk);
    rd_now(8'h1C, d); check("R7 rearmed expiry", d, 32'h1);
    wr(8'h84, 32'h12345678);
    wr(8'h1C, 32'h0);

    // R9 hold in reset
    wr(8'h24, 32'h1);
    wr(8'h84, 32'h92345678);
    wr(8'h00, 32'h0);
    @(negedge clk);
    rd_now(8'h24, d); check("R9 doorbell cleared", d, 32'h0);
    rd_now(8'h60, d); check("R9 pc zero", d, 32'h0);
    check("R2 ctl_run low", {31'd0, ctl_run}, 32'd0);
    wr(8'h24, 32'h1);
    rd_now(8'h24, d); check("R9 doorbell write ignored", d, 32'h0);
    repeat (2*L) @(negedge clk);
    rd_now(8'h1C, d); check("R9 watchdog held", d, 32'h0);

    // R10 unmapped writes
    wr(8'h10, 32'hFFFFFFFF);
    wr(8'h04, 32'hFFFFFFFF);
    rd_now(8'h08, d); check("R10 split unchanged", d, 32'h2);
    rd_now(8'h84, d); check("R10 watchdog unchanged", d, 32'h92345678);
    rd_now(8'h00, d); check("R10 run unchanged", d, 32'h0);
    rd_now(8'h10, d); check("R10 unmapped reads zero", d, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule